// File: doc/BRIEF.md
# Serial EEPROM Write-Path Bus Target

This block is the bus-facing part of a small serial EEPROM that handles only writes. It samples the two-wire bus (SCL and SDA) with the system clock and finds START and STOP conditions. It shifts in bytes MSB first and drives the acknowledge by enabling an open-drain pull-down on SDA. The first byte after START selects the device. The block then hands every later byte to a page-buffer engine through a one-cycle strobe. The first forwarded byte of a transfer carries a flag that marks it as the word address.

The page-buffer engine reports a busy level while its internal write cycle runs. While that level is high the block acknowledges nothing, not even its own control byte. When a STOP ends a transfer that delivered at least one data byte, the block raises a one-cycle commit pulse so that the engine starts its write cycle.

Top module: `eewt_top`

## Requirements
- R1: After reset, `sda_oe`, `byte_vld` and `commit` are all low.
- R2: The first byte after START is a control byte read MSB first, with bits [7:4] the device code, bits [3:1] the chip-select bits and bit [0] the direction bit. It is acknowledged when the code equals `DEV_CODE`, the chip-select bits equal `cs_strap` and the direction bit is 0.
- R3: A control byte whose device code or chip-select bits do not match gets no acknowledge. Every later byte up to the next START then gets no acknowledge and no `byte_vld`.
- R4: A control byte with the direction bit at 1 gets no acknowledge and is treated like a mismatch.
- R5: The byte after an accepted control byte is acknowledged and forwarded with `byte_first`=1. Each later byte is acknowledged and forwarded with `byte_first`=0. `byte_data` equals the byte as sent, and `byte_vld` is high for exactly one cycle per byte.
- R6: While `wr_busy` is high when a byte completes, that byte (control, address or data) gets no acknowledge and is not forwarded. The block then ignores the bus until the next START, and the transfer can no longer commit.
- R7: A STOP that follows at least one forwarded data byte gives a `commit` pulse that lasts one cycle. A STOP that follows only the word address, or no accepted byte at all, gives none.
- R8: A START seen anywhere, even in the middle of a byte, restarts bit counting at a new control byte.
- R9: `sda_oe` changes only while SCL is low. It rises after the falling edge of the 8th clock of an acknowledged byte and falls after the falling edge of the 9th clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled |
| cs_strap | input | 3 | Chip-select strap value compared against control byte bits [3:1] |
| wr_busy | input | 1 | High while the page-buffer engine runs its internal write cycle |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low (acknowledge) |
| byte_vld | output | 1 | One-cycle strobe for a received address or data byte |
| byte_data | output | 8 | Byte value, valid with `byte_vld` |
| byte_first | output | 1 | Marks the strobed byte as the word address |
| commit | output | 1 | One-cycle pulse that starts the internal write cycle |

## Verification
The block is driven with a single-byte write and with a five-byte page write. These two tell apart a single forwarded data byte from a stream of data bytes and show whether the address flag appears only once. The control byte is sent matching, with a wrong device code, with wrong chip-select bits and with the read bit set, which separates the three reasons for refusal. A transfer ending right after the address and a busy level raised in the middle of a transfer show the difference between forwarding and committing. A START cut into a half-sent byte shows whether the bit counter really restarts.

// File: rtl/eewt_pkg.sv
// Package: shared widths, phase encoding and the control-byte decode.
// Assumes a byte-wide bus protocol with one acknowledge slot per byte.
package eewt_pkg;

    localparam int BYTE_W   = 8;
    localparam int CODE_W   = 4;
    localparam int CS_W     = 3;
    localparam int ACK_SLOT = BYTE_W + 1;
    localparam int CNT_W    = $clog2(ACK_SLOT + 1);

    // Which byte of a transfer is being received.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CTRL = 2'd1,
        PH_ADDR = 2'd2,
        PH_DATA = 2'd3
    } phase_t;

    // True when a control byte selects this device for a write.
    function automatic logic ctrl_selects(input logic [BYTE_W-1:0] cb,
                                          input logic [CODE_W-1:0] code,
                                          input logic [CS_W-1:0]   cs);
        return (cb[BYTE_W-1 -: CODE_W] == code) &&
               (cb[CS_W:1] == cs) &&
               (cb[0] == 1'b0);
    endfunction

endpackage

// File: rtl/eewt_sync.sv
// Module: multi-stage synchronizer for asynchronous bus lines.
// Assumes the lines idle high, so every stage resets to 1.
module eewt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= din;
                end
            end else begin : g_next
                // Later stages let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/eewt_cond.sv
// Module: finds clock edges and START/STOP conditions on the synchronized lines.
// Assumes both inputs come through the same synchronizer depth.
module eewt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_p;
    logic sda_p;

    // Keep the previous sample of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Edge and condition decode; SDA moving under a steady high SCL is a condition.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/eewt_top.sv
// Module: write-only bus target front end for a serial EEPROM.
// Receives the control byte, the word address and data bytes, drives the
// acknowledge, forwards bytes to a page-buffer engine and asks it to commit
// on STOP. Assumes the system clock samples each SCL phase at least four times.
module eewt_top
    import eewt_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEV_CODE    = 4'b1010,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [CS_W-1:0]   cs_strap,
    input  logic              wr_busy,
    output logic              sda_oe,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_first,
    output logic              commit
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    phase_t            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              data_seen;
    logic              accept;

    eewt_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  ({scl_s, sda_s})
    );

    eewt_cond cond_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // Decide whether the byte just completed earns an acknowledge.
    always_comb begin
        if (wr_busy)               accept = 1'b0;
        else if (phase == PH_CTRL) accept = ctrl_selects(shreg, DEV_CODE, cs_strap);
        else                       accept = (phase == PH_ADDR) || (phase == PH_DATA);
    end

    // Byte framing, acknowledge drive, forwarding and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            sda_oe     <= 1'b0;
            byte_vld   <= 1'b0;
            byte_data  <= '0;
            byte_first <= 1'b0;
            commit     <= 1'b0;
            data_seen  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            commit   <= 1'b0;
            if (start_det) begin
                phase     <= PH_CTRL;
                bit_cnt   <= '0;
                sda_oe    <= 1'b0;
                data_seen <= 1'b0;
            end else if (stop_det) begin
                commit    <= data_seen;
                phase     <= PH_IDLE;
                bit_cnt   <= '0;
                sda_oe    <= 1'b0;
                data_seen <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (bit_cnt < CNT_W'(BYTE_W))
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                    if (bit_cnt <= CNT_W'(BYTE_W))
                        bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall) begin
                    if (bit_cnt == CNT_W'(BYTE_W)) begin
                        if (accept) begin
                            sda_oe <= 1'b1;
                            if (phase != PH_CTRL) begin
                                byte_vld   <= 1'b1;
                                byte_data  <= shreg;
                                byte_first <= (phase == PH_ADDR);
                            end
                            if (phase == PH_DATA) data_seen <= 1'b1;
                        end else begin
                            phase     <= PH_IDLE;
                            bit_cnt   <= '0;
                            data_seen <= 1'b0;
                        end
                    end else if (bit_cnt == CNT_W'(ACK_SLOT)) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        if (phase == PH_CTRL)      phase <= PH_ADDR;
                        else if (phase == PH_ADDR) phase <= PH_DATA;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/eewt_chk.sv
// Checker: protocol properties of the write front end, bound to eewt_top.
// Assumes scl_s is the synchronized clock line inside the top module.
module eewt_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic wr_busy,
    input logic byte_vld,
    input logic commit
);

    // R9: the acknowledge drive moves only after SCL was seen low
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    // R6: no acknowledge starts from a decision taken while busy
    p_no_ack_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(wr_busy));

    // R5: a forwarded byte is always one being acknowledged
    p_vld_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> sda_oe);

    // R7: commit lasts one cycle
    p_commit_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R7: commit and a byte strobe never share a cycle
    p_vld_commit_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_vld, commit}));

endmodule

bind eewt_top eewt_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .wr_busy  (wr_busy),
    .byte_vld (byte_vld),
    .commit   (commit)
);

// File: tb/eewt_top_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, driving an open-drain bus model.
module eewt_top_tb_top;

    localparam logic [3:0] CODE = 4'b1010;
    localparam logic [2:0] CS   = 3'b101;
    localparam int QTR  = 6;
    localparam int HIGH = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       wr_busy = 1'b0;
    logic       sda_oe;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       byte_first;
    logic       commit;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    int n_log  = 0;
    int n_commit = 0;
    logic [7:0] log_d [16];
    logic       log_f [16];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    eewt_top #(.DEV_CODE(CODE)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .cs_strap   (CS),
        .wr_busy    (wr_busy),
        .sda_oe     (sda_oe),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .byte_first (byte_first),
        .commit     (commit)
    );

    // Monitor: record forwarded bytes and commit pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && byte_vld) begin
            if (n_log < 16) begin
                log_d[n_log] = byte_data;
                log_f[n_log] = byte_first;
            end
            n_log = n_log + 1;
        end
        if (rst_n && commit) n_commit = n_commit + 1;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic clear_log();
        n_log = 0;
        n_commit = 0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(QTR);
        scl = 1'b1;   wait_clk(HIGH);
        sda_m = 1'b0; wait_clk(HIGH);
        scl = 1'b0;   wait_clk(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(QTR);
        scl = 1'b1;   wait_clk(HIGH);
        sda_m = 1'b1; wait_clk(HIGH);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wait_clk(QTR);
            scl = 1'b1;   wait_clk(HIGH);
            scl = 1'b0;   wait_clk(QTR);
        end
    endtask

    // Send one byte and return whether SDA was pulled low in the 9th clock.
    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; wait_clk(QTR);
        scl = 1'b1;   wait_clk(HIGH / 2);
        acked = ~sda_line;
        wait_clk(HIGH / 2);
        scl = 1'b0;   wait_clk(QTR);
        check(sda_oe == 1'b0, "R9 oe released after 9th clock", sda_oe, 0);
    endtask

    function automatic logic [7:0] ctrl(input logic [3:0] c, input logic [2:0] s, input logic rw);
        return {c, s, rw};
    endfunction

    task automatic t_reset();
        check(sda_oe == 1'b0,   "R1 sda_oe", sda_oe, 0);
        check(byte_vld == 1'b0, "R1 byte_vld", byte_vld, 0);
        check(commit == 1'b0,   "R1 commit", commit, 0);
    endtask

    task automatic t_byte_write();
        logic a;
        clear_log();
        bus_start();
        send_byte(ctrl(CODE, CS, 1'b0), a);
        check(a == 1'b1, "R2 control ack", a, 1);
        send_byte(8'h35, a);
        check(a == 1'b1, "R5 address ack", a, 1);
        send_byte(8'hA7, a);
        check(a == 1'b1, "R5 data ack", a, 1);
        bus_stop();
        wait_clk(4);
        check(n_log == 2, "R5 forwarded count", n_log, 2);
        check(log_d[0] == 8'h35 && log_f[0] == 1'b1, "R5 address byte", {log_f[0], log_d[0]}, 9'h135);
        check(log_d[1] == 8'hA7 && log_f[1] == 1'b0, "R5 data byte", {log_f[1], log_d[1]}, 9'h0A7);
        check(n_commit == 1, "R7 commit after data", n_commit, 1);
    endtask

    task automatic t_page_write();
        logic a;
        logic [7:0] d;
        clear_log();
        bus_start();
        send_byte(ctrl(CODE, CS, 1'b0), a);
        send_byte(8'h7C, a);
        for (int k = 0; k < 4; k++) begin
            d = 8'h10 * k[7:0] + 8'h0F - k[7:0];
            send_byte(d, a);
            check(a == 1'b1, "R5 page data ack", a, 1);
        end
        bus_stop();
        wait_clk(4);
        check(n_log == 5, "R5 page forwarded count", n_log, 5);
        check(log_f[0] == 1'b1 && log_d[0] == 8'h7C, "R5 page address", {log_f[0], log_d[0]}, 9'h17C);
        for (int k = 0; k < 4; k++) begin
            d = 8'h10 * k[7:0] + 8'h0F - k[7:0];
            check(log_f[k+1] == 1'b0 && log_d[k+1] == d, "R5 page data", {log_f[k+1], log_d[k+1]}, {1'b0, d});
        end
        check(n_commit == 1, "R7 page commit", n_commit, 1);
    endtask

    task automatic t_addr_only();
        logic a;
        clear_log();
        bus_start();
        send_byte(ctrl(CODE, CS, 1'b0), a);
        send_byte(8'h02, a);
        bus_stop();
        wait_clk(4);
        check(n_log == 1, "R7 address forwarded", n_log, 1);
        check(n_commit == 0, "R7 no commit without data", n_commit, 0);
    endtask

    task automatic t_bad_code();
        logic a;
        clear_log();
        bus_start();
        send_byte(ctrl(4'b1011, CS, 1'b0), a);
        check(a == 1'b0, "R3 wrong code nack", a, 0);
        send_byte(8'h44, a);
        check(a == 1'b0, "R3 later byte nack", a, 0);
        send_byte(8'h55, a);
        bus_stop();
        wait_clk(4);
        check(n_log == 0, "R3 nothing forwarded", n_log, 0);
        check(n_commit == 0, "R3 no commit", n_commit, 0);
    endtask

    task automatic t_bad_cs();
        logic a;
        clear_log();
        bus_start();
        send_byte(ctrl(CODE, 3'b100, 1'b0), a);
        check(a == 1'b0, "R3 wrong chip select nack", a, 0);
        send_byte(8'h12, a);
        bus_stop();
        wait_clk(4);
        check(n_log == 0, "R3 chip select nothing forwarded", n_log, 0);
    endtask

    task automatic t_read_dir();
        logic a;
        clear_log();
        bus_start();
        send_byte(ctrl(CODE, CS, 1'b1), a);
        check(a == 1'b0, "R4 read direction nack", a, 0);
        send_byte(8'h20, a);
        check(a == 1'b0, "R4 following byte nack", a, 0);
        bus_stop();
        wait_clk(4);
        check(n_log == 0, "R4 nothing forwarded", n_log, 0);
    endtask

    task automatic t_busy();
        logic a;
        clear_log();
        wr_busy = 1'b1;
        bus_start();
        send_byte(ctrl(CODE, CS, 1'b0), a);
        check(a == 1'b0, "R6 control nack while busy", a, 0);
        bus_stop();
        wr_busy = 1'b0;
        bus_start();
        send_byte(ctrl(CODE, CS, 1'b0), a);
        send_byte(8'h40, a);
        check(a == 1'b1, "R6 address ack when idle", a, 1);
        wr_busy = 1'b1;
        send_byte(8'h99, a);
        check(a == 1'b0, "R6 data nack while busy", a, 0);
        bus_stop();
        wr_busy = 1'b0;
        wait_clk(4);
        check(n_log == 1, "R6 busy byte not forwarded", n_log, 1);
        check(n_commit == 0, "R6 no commit after refusal", n_commit, 0);
    endtask

    task automatic t_restart();
        logic a;
        clear_log();
        bus_start();
        send_bits(8'hF3, 4);
        bus_start();
        send_byte(ctrl(CODE, CS, 1'b0), a);
        check(a == 1'b1, "R8 control ack after repeated start", a, 1);
        send_byte(8'h11, a);
        send_byte(8'hC4, a);
        bus_stop();
        wait_clk(4);
        check(n_log == 2 && log_d[1] == 8'hC4, "R8 data after restart", log_d[1], 8'hC4);
        check(n_commit == 1, "R8 commit after restart", n_commit, 1);
    endtask

    initial begin
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(5);
        t_byte_write();
        t_page_write();
        t_addr_only();
        t_bad_code();
        t_bad_cs();
        t_read_dir();
        t_busy();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait_clk(150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule